// File: doc/BRIEF.md
# Fine-Grain PRG/CHR Bank Register File

This block is the extended banking unit of a cartridge mapper. It watches CPU writes and turns them into a 6-bit PRG bank number for each of the four 8 KiB CPU windows at 0x8000–0xFFFF. It also produces an 8-bit CHR bank number for each of the eight 1 KiB PPU windows at 0x0000–0x1FFF.

Two extended PRG modes exist. The 256 KiB mode takes four bank bits from each window register and one shared high bit from a control register. The 512 KiB mode takes six bits straight from each window register. When neither mode is on, the PRG banks supplied by the simpler latch mapper pass through unchanged.

CHR banking works in one of two ways. It can use one shared 2-bit 8 KiB select, or, in 1 KiB mode, eight separate bank registers. Those eight registers, the mode register and the CHR bank currently addressed by the PPU can all be read back.

Top module: `fine_bank_regfile`

## Requirements
- R1: After synchronous reset every register is zero, so `ext_prg_active` is 0, each PRG window follows `latch_prg`, every CHR window i shows bank i, and all readable locations return 0.
- R2: A write anywhere in 0x8000–0xFFFF loads the window register chosen by address bits 14:13, even while both extended modes are off. The stored value takes effect as soon as a mode is switched on later.
- R3: A write to 0x43FE turns the 256 KiB mode on and a write to 0x43FF turns it off (address bit 0 is 0 for on, 1 for off). In this mode window w gets bank {0, H, D[5:2]}, where D is window register w and H is the shared high bit.
- R4: The shared high bit H is data bit 6 of the last write to 0x43FE or 0x43FF, and it applies to all four windows together.
- R5: Bit 7 of the mode register at 0x4411 turns on the 512 KiB mode. In that mode window w gets bank D[7:2], and this mode wins over the 256 KiB mode.
- R6: With both extended modes off, `ext_prg_active` is 0 and `prg_bank` equals `latch_prg`. With either mode on, `ext_prg_active` is 1.
- R7: Data bits 1:0 of any write to 0x8000–0xFFFF or to 0x43FE/0x43FF set the shared 8 KiB CHR select C. With 1 KiB mode off, PPU window i (i = 0..7) gets bank 8·C + i.
- R8: Bit 6 of the mode register turns on 1 KiB CHR mode. In that mode PPU window i gets the 8-bit value written to 0x4400+i.
- R9: A read (combinational on `cpu_addr`) of 0x4400–0x4407 returns the matching 1 KiB register, 0x4411 returns the mode register, and any other address except 0x4420 returns 0.
- R10: A read of 0x4420 returns the 1 KiB register selected by `ppu_addr[12:10]`. `chr_bank_now` gives the bank in effect for the current PPU address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU address, used for writes and reads |
| cpu_wdata | input | 8 | CPU write data |
| cpu_we | input | 1 | CPU write strobe, one write per cycle |
| cpu_rdata | output | 8 | Read data for the addressed register |
| ppu_addr | input | 13 | PPU pattern address |
| latch_prg | input | 24 | Latch mapper PRG banks, window w in bits 6w+5:6w |
| prg_bank | output | 24 | Effective PRG bank per CPU window, same layout |
| ext_prg_active | output | 1 | An extended PRG mode is overriding the latch |
| chr_bank | output | 64 | Effective CHR bank per 1 KiB PPU window, window i in bits 8i+7:8i |
| chr_bank_now | output | 8 | CHR bank for the current `ppu_addr` |

## Verification
The hardest case to reach is a stored window value that becomes visible only after a later mode change. This happens when window registers are written while both modes are off, and then the 512 KiB and 256 KiB enables are switched in either order. Directed sequences create each order. These include turning off 256 KiB mode while 512 KiB mode stays on, and changing the shared high bit through the disable address. A long random phase then mixes window, control, mode and 1 KiB writes, with `ppu_addr` and the read address swept. A behavioural model is compared against every output on every cycle.

// File: rtl/fbr_pkg.sv
package fbr_pkg;

    localparam int DATA_W    = 8;
    localparam int PRG_W     = 6;
    localparam int WINDOWS   = 4;
    localparam int CHR_W     = 8;
    localparam int SLOTS     = 8;
    localparam int WIN_IDX_W = $clog2(WINDOWS);
    localparam int SLOT_IDX_W = $clog2(SLOTS);

    localparam logic [15:0] ADDR_CTL_BASE  = 16'h43FE;
    localparam logic [15:0] ADDR_MODE      = 16'h4411;
    localparam logic [15:0] ADDR_SLOT_BASE = 16'h4400;
    localparam logic [15:0] ADDR_CUR_SLOT  = 16'h4420;

    localparam int MODE_BIT_512 = 7;
    localparam int MODE_BIT_1K  = 6;
    localparam int CTL_BIT_HI   = 6;

    typedef struct packed {
        logic                  win_we;
        logic [WIN_IDX_W-1:0]  win_idx;
        logic                  ctl_we;
        logic                  ctl_off;
        logic                  mode_we;
        logic                  slot_we;
        logic [SLOT_IDX_W-1:0] slot_idx;
    } wr_strobe_t;

    typedef struct packed {
        logic [WINDOWS-1:0][DATA_W-1:0] win;
        logic                           en256;
        logic                           prg_hi;
        logic [1:0]                     chr8k;
        logic [DATA_W-1:0]              mode;
        logic [SLOTS-1:0][CHR_W-1:0]    slot;
    } bank_state_t;

    typedef enum logic [1:0] {
        PRG_SRC_LATCH = 2'd0,
        PRG_SRC_256   = 2'd1,
        PRG_SRC_512   = 2'd2
    } prg_src_e;

    function automatic logic [PRG_W-1:0] bank_from_reg(
        input prg_src_e         src,
        input logic [DATA_W-1:0] r,
        input logic              hi,
        input logic [PRG_W-1:0]  latch
    );
        logic [PRG_W-1:0] b;
        unique case (src)
            PRG_SRC_512: b = r[7:2];
            PRG_SRC_256: b = {1'b0, hi, r[5:2]};
            default:     b = latch;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/fbr_decode.sv
module fbr_decode
    import fbr_pkg::*;
(
    input  logic [15:0] cpu_addr,
    input  logic        cpu_we,
    output wr_strobe_t  strobe
);
    always_comb begin
        strobe          = '0;
        strobe.win_idx  = cpu_addr[14:13];
        strobe.slot_idx = cpu_addr[SLOT_IDX_W-1:0];
        strobe.ctl_off  = cpu_addr[0];
        if (cpu_we) begin
            strobe.win_we  = cpu_addr[15];
            strobe.ctl_we  = (cpu_addr[15:1] == ADDR_CTL_BASE[15:1]);
            strobe.mode_we = (cpu_addr == ADDR_MODE);
            strobe.slot_we = (cpu_addr[15:SLOT_IDX_W] == ADDR_SLOT_BASE[15:SLOT_IDX_W]);
        end
    end
endmodule

// File: rtl/fbr_regs.sv
module fbr_regs
    import fbr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  wr_strobe_t        strobe,
    input  logic [DATA_W-1:0] wdata,
    output bank_state_t       st
);
    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else begin
            if (strobe.win_we) begin
                st.win[strobe.win_idx] <= wdata;
                st.chr8k               <= wdata[1:0];
            end
            if (strobe.ctl_we) begin
                st.en256  <= ~strobe.ctl_off;
                st.prg_hi <= wdata[CTL_BIT_HI];
                st.chr8k  <= wdata[1:0];
            end
            if (strobe.mode_we) begin
                st.mode <= wdata;
            end
            if (strobe.slot_we) begin
                st.slot[strobe.slot_idx] <= wdata;
            end
        end
    end
endmodule

// File: rtl/fbr_prg_map.sv
module fbr_prg_map
    import fbr_pkg::*;
(
    input  bank_state_t                  st,
    input  logic [WINDOWS*PRG_W-1:0]     latch_prg,
    output logic [WINDOWS*PRG_W-1:0]     prg_bank,
    output logic                         ext_active
);
    prg_src_e src;

    always_comb begin
        if (st.mode[MODE_BIT_512])  src = PRG_SRC_512;
        else if (st.en256)          src = PRG_SRC_256;
        else                        src = PRG_SRC_LATCH;
    end

    assign ext_active = (src != PRG_SRC_LATCH);

    for (genvar w = 0; w < WINDOWS; w++) begin : g_win
        assign prg_bank[w*PRG_W +: PRG_W] =
            bank_from_reg(src, st.win[w], st.prg_hi, latch_prg[w*PRG_W +: PRG_W]);
    end
endmodule

// File: rtl/fbr_chr_map.sv
module fbr_chr_map
    import fbr_pkg::*;
(
    input  bank_state_t              st,
    input  logic [12:0]              ppu_addr,
    output logic [SLOTS*CHR_W-1:0]   chr_bank,
    output logic [CHR_W-1:0]         chr_now,
    output logic [CHR_W-1:0]         slot_now
);
    localparam int PAD_W = CHR_W - 2 - SLOT_IDX_W;

    logic [SLOT_IDX_W-1:0] sel;
    assign sel = ppu_addr[12:10];

    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
        localparam logic [SLOT_IDX_W-1:0] IDX = SLOT_IDX_W'(i);
        assign chr_bank[i*CHR_W +: CHR_W] = st.mode[MODE_BIT_1K] ? st.slot[i]
                                          : {{PAD_W{1'b0}}, st.chr8k, IDX};
    end

    assign chr_now  = chr_bank[sel*CHR_W +: CHR_W];
    assign slot_now = st.slot[sel];
endmodule

// File: rtl/fine_bank_regfile.sv
module fine_bank_regfile
    import fbr_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [15:0] cpu_addr,
    input  logic [7:0]  cpu_wdata,
    input  logic        cpu_we,
    output logic [7:0]  cpu_rdata,
    input  logic [12:0] ppu_addr,
    input  logic [23:0] latch_prg,
    output logic [23:0] prg_bank,
    output logic        ext_prg_active,
    output logic [63:0] chr_bank,
    output logic [7:0]  chr_bank_now
);
    wr_strobe_t        strobe;
    bank_state_t       st;
    logic [CHR_W-1:0]  slot_now;

    fbr_decode u_dec (
        .cpu_addr (cpu_addr),
        .cpu_we   (cpu_we),
        .strobe   (strobe)
    );

    fbr_regs u_regs (
        .clk    (clk),
        .rst    (rst),
        .strobe (strobe),
        .wdata  (cpu_wdata),
        .st     (st)
    );

    fbr_prg_map u_prg (
        .st         (st),
        .latch_prg  (latch_prg),
        .prg_bank   (prg_bank),
        .ext_active (ext_prg_active)
    );

    fbr_chr_map u_chr (
        .st       (st),
        .ppu_addr (ppu_addr),
        .chr_bank (chr_bank),
        .chr_now  (chr_bank_now),
        .slot_now (slot_now)
    );

    always_comb begin
        cpu_rdata = '0;
        if (cpu_addr[15:SLOT_IDX_W] == ADDR_SLOT_BASE[15:SLOT_IDX_W])
            cpu_rdata = st.slot[cpu_addr[SLOT_IDX_W-1:0]];
        else if (cpu_addr == ADDR_MODE)
            cpu_rdata = st.mode;
        else if (cpu_addr == ADDR_CUR_SLOT)
            cpu_rdata = slot_now;
    end
endmodule

// File: rtl/fbr_checker.sv
module fbr_checker (
    input logic        clk,
    input logic        rst,
    input logic [15:0] cpu_addr,
    input logic [7:0]  cpu_wdata,
    input logic        cpu_we,
    input logic [7:0]  cpu_rdata,
    input logic        ext_prg_active,
    input logic [23:0] prg_bank,
    input logic [63:0] chr_bank,
    input logic [7:0]  mode_q,
    input logic [12:0] ppu_addr
);
    AST_RESET_OFF: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!ext_prg_active && chr_bank[7:0] == 8'd0)); // R1

    AST_CTL_ENABLE: assert property (@(posedge clk) disable iff (rst)
        (cpu_we && cpu_addr == 16'h43FE) |=> ext_prg_active); // R3

    AST_CTL_DISABLE: assert property (@(posedge clk) disable iff (rst)
        (cpu_we && cpu_addr == 16'h43FF && !mode_q[7]) |=> !ext_prg_active); // R3

    AST_WIN512_LOAD: assert property (@(posedge clk) disable iff (rst)
        (cpu_we && cpu_addr[15:13] == 3'b100 && mode_q[7])
        |=> prg_bank[5:0] == $past(cpu_wdata[7:2])); // R5

    AST_CC_LOAD: assert property (@(posedge clk) disable iff (rst)
        (cpu_we && cpu_addr[15] && !mode_q[6])
        |=> chr_bank[7:0] == {3'b000, $past(cpu_wdata[1:0]), 3'b000}); // R7

    AST_CUR_SLOT_READ: assert property (@(posedge clk) disable iff (rst)
        (mode_q[6] && cpu_addr == 16'h4420)
        |-> cpu_rdata == chr_bank[ppu_addr[12:10]*8 +: 8]); // R10
endmodule

bind fine_bank_regfile fbr_checker u_chk (
    .clk            (clk),
    .rst            (rst),
    .cpu_addr       (cpu_addr),
    .cpu_wdata      (cpu_wdata),
    .cpu_we         (cpu_we),
    .cpu_rdata      (cpu_rdata),
    .ext_prg_active (ext_prg_active),
    .prg_bank       (prg_bank),
    .chr_bank       (chr_bank),
    .mode_q         (st.mode),
    .ppu_addr       (ppu_addr)
);

// File: tb/fine_bank_regfile_test.sv
module fine_bank_regfile_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] cpu_addr = 16'h0000;
    logic [7:0]  cpu_wdata = 8'h00;
    logic        cpu_we = 1'b0;
    logic [7:0]  cpu_rdata;
    logic [12:0] ppu_addr = 13'h0000;
    logic [23:0] latch_prg = 24'h000000;
    logic [23:0] prg_bank;
    logic        ext_prg_active;
    logic [63:0] chr_bank;
    logic [7:0]  chr_bank_now;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    // behavioural model state
    int m_win[4];
    int m_slot[8];
    int m_mode, m_en, m_hi, m_cc;

    always #4 clk = ~clk;   // 125 MHz

    fine_bank_regfile uut (
        .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_we(cpu_we), .cpu_rdata(cpu_rdata), .ppu_addr(ppu_addr),
        .latch_prg(latch_prg), .prg_bank(prg_bank), .ext_prg_active(ext_prg_active),
        .chr_bank(chr_bank), .chr_bank_now(chr_bank_now)
    );

    task automatic chk(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 4; i++) m_win[i] = 0;
        for (int i = 0; i < 8; i++) m_slot[i] = 0;
        m_mode = 0; m_en = 0; m_hi = 0; m_cc = 0;
    endtask

    task automatic model_write(input int a, input int d);
        if (a >= 'h8000) begin
            m_win[(a >> 13) & 3] = d;
            m_cc = d & 3;
        end
        if (a == 'h43FE || a == 'h43FF) begin
            m_en = (a == 'h43FE);
            m_hi = (d >> 6) & 1;
            m_cc = d & 3;
        end
        if (a == 'h4411) m_mode = d;
        if (a >= 'h4400 && a <= 'h4407) m_slot[a - 'h4400] = d;
    endtask

    function automatic int exp_prg(input int w);
        if (m_mode[7]) return (m_win[w] >> 2) & 63;
        if (m_en != 0) return (m_hi << 4) | ((m_win[w] >> 2) & 15);
        return (latch_prg >> (6 * w)) & 63;
    endfunction

    function automatic int exp_chr(input int i);
        if (m_mode[6]) return m_slot[i];
        return m_cc * 8 + i;
    endfunction

    function automatic int exp_rd(input int a);
        if (a >= 'h4400 && a <= 'h4407) return m_slot[a - 'h4400];
        if (a == 'h4411) return m_mode;
        if (a == 'h4420) return m_slot[(ppu_addr >> 10) & 7];
        return 0;
    endfunction

    // per-cycle comparison, away from the edge
    always @(posedge clk) begin
        #2;
        if (!rst && !done) begin
            string ptag;
            ptag = m_mode[7] ? "R5" : ((m_en != 0) ? "R3" : "R6");
            for (int w = 0; w < 4; w++)
                chk(int'(prg_bank[6*w +: 6]), exp_prg(w), ptag);
            chk(int'(ext_prg_active), int'(m_mode[7] || m_en != 0), "R6");
            for (int i = 0; i < 8; i++)
                chk(int'(chr_bank[8*i +: 8]), exp_chr(i), m_mode[6] ? "R8" : "R7");
            chk(int'(chr_bank_now), exp_chr((ppu_addr >> 10) & 7), "R10");
            chk(int'(cpu_rdata), exp_rd(cpu_addr), (cpu_addr == 16'h4420) ? "R10" : "R9");
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; cpu_we = 1'b0;
        repeat (3) @(posedge clk);
        model_reset();
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_wdata = d; cpu_we = 1'b1;
        @(posedge clk);
        #1 model_write(a, d);
        @(negedge clk);
        cpu_we = 1'b0;
    endtask

    task automatic rd_at(input logic [15:0] a);
        @(negedge clk);
        cpu_addr = a;
        @(posedge clk);
        #3;
    endtask

    initial begin
        #(200000 * 8);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        model_reset();
        latch_prg = 24'hA5C3_96;
        do_reset();
        // R1: reset state seen at the ports
        rd_at(16'h4411);
        chk(int'(ext_prg_active), 0, "R1");
        chk(int'(prg_bank), int'(latch_prg), "R1");
        chk(int'(cpu_rdata), 0, "R1");
        chk(int'(chr_bank[8*5 +: 8]), 5, "R1");

        // R2: windows captured while modes are off
        wr(16'h8000, 8'hFC);
        wr(16'hA123, 8'h08);
        wr(16'hC000, 8'h54);
        wr(16'hFFFF, 8'h2E);
        chk(int'(prg_bank), int'(latch_prg), "R2");
        latch_prg = 24'h12_3456;
        // enable 512 first
        wr(16'h4411, 8'h80);
        chk(int'(prg_bank[5:0]), 6'h3F, "R2");
        chk(int'(prg_bank[11:6]), 6'h02, "R2");
        // 256 mode enabled underneath; 512 keeps priority
        wr(16'h43FE, 8'h40);
        chk(int'(prg_bank[17:12]), 6'h15, "R5");
        // drop 512: 256 rules, hi bit = 1 for all windows (R4)
        wr(16'h4411, 8'h00);
        chk(int'(prg_bank[5:0]), 6'h1F, "R4");
        chk(int'(prg_bank[23:18]), 6'h1B, "R4");
        // disable via 0x43FF with hi bit 0
        wr(16'h43FF, 8'h03);
        chk(int'(ext_prg_active), 0, "R3");
        // disable address with 512 on keeps active
        wr(16'h4411, 8'h80);
        wr(16'h43FF, 8'h00);
        chk(int'(ext_prg_active), 1, "R5");
        wr(16'h4411, 8'h00);
        // R7: CHR select from control and window writes
        wr(16'h43FE, 8'h02);
        chk(int'(chr_bank[8*3 +: 8]), 19, "R7");
        wr(16'hE000, 8'h01);
        chk(int'(chr_bank[8*7 +: 8]), 15, "R7");
        // R8: 1 KiB registers
        for (int i = 0; i < 8; i++) wr(16'h4400 + 16'(i), 8'(8'hF0 - 8'(i * 17)));
        wr(16'h4411, 8'h40);
        chk(int'(chr_bank[8*2 +: 8]), 8'hF0 - 34, "R8");
        // R9/R10 reads
        for (int i = 0; i < 8; i++) begin
            ppu_addr = 13'(i * 1024 + 5);
            rd_at(16'h4420);
            chk(int'(cpu_rdata), int'(8'hF0 - 8'(i * 17)), "R10");
        end
        rd_at(16'h4411); chk(int'(cpu_rdata), 8'h40, "R9");
        rd_at(16'h4408); chk(int'(cpu_rdata), 0, "R9");
        rd_at(16'h43FE); chk(int'(cpu_rdata), 0, "R9");

        // random mix
        for (int n = 0; n < 1500; n++) begin
            logic [15:0] a;
            int k;
            k = $urandom_range(0, 7);
            case (k)
                0, 1: a = 16'h8000 | 16'($urandom_range(0, 16'h7FFF));
                2:    a = 16'h43FE | 16'($urandom_range(0, 1));
                3:    a = 16'h4411;
                4, 5: a = 16'h4400 | 16'($urandom_range(0, 7));
                default: a = 16'h4000 | 16'($urandom_range(0, 16'h3F));
            endcase
            ppu_addr  = 13'($urandom);
            latch_prg = 24'($urandom);
            if (k == 7) rd_at(a);
            else wr(a, 8'($urandom));
        end
        do_reset();
        rd_at(16'h4400);
        chk(int'(cpu_rdata), 0, "R1");
        @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule